// File: doc/BRIEF.md
# Processor Reset Supervisor with Activity Watchdog

This block is the digital core of a processor supervisor. It receives a power-good level that an external comparator has already synchronized, together with a watchdog input that has already been decoded into two signals. One is a logic level. The other flags that the pin sits at mid-supply or is left floating. From these it drives an active-low system reset, the active-high complement of that reset, and an active-low watchdog status flag.

Reset is held for as long as power is bad. After power recovers, a stretcher keeps reset asserted for a set number of clock cycles. A watchdog counter measures the time between edges of the level input, and either edge polarity counts as activity. If no edge arrives within the timeout, the counter fires a reset pulse of full stretch length. It keeps firing pulses for as long as the input stays stuck. The status flag drops on a timeout. It recovers only on the next input edge, or when power is lost. A mid-level input switches the watchdog off. Both time bases are given in clock cycles.

Top module: `proc_supervisor`

## Requirements
- R1: While `pwr_good_i` is 0, `rst_out_n_o` is 0 from the next clock edge on. Right after the asynchronous `rst_n` is released, `rst_out_n_o` is 0 and `wd_stat_n_o` is 1.
- R2: Once `pwr_good_i` is 1, `rst_out_n_o` stays 0 through the first HOLD_CYCLES-1 clock edges and goes to 1 at edge HOLD_CYCLES.
- R3: Each rising or falling edge of `wd_level_i` reaches the watchdog 3 clock edges after it is applied (two synchronizer flops plus edge compare) and restarts the timeout count. Edges spaced closer than WD_TIMEOUT cycles never cause a reset. A timeout is counted from the last edge.
- R4: WD_TIMEOUT cycles after counting starts with no edge, `wd_stat_n_o` goes to 0. On the next edge `rst_out_n_o` goes to 0 and stays there for exactly HOLD_CYCLES cycles.
- R5: While `wd_level_i` stays constant, reset pulses repeat. The next one starts WD_TIMEOUT+1 cycles after the previous pulse ends.
- R6: `wd_stat_n_o` returns to 1 on the next recognized edge of `wd_level_i`, including an edge during a reset pulse. The timeout count stays at zero while reset is asserted.
- R7: While `wd_float_i` is 1, `wd_stat_n_o` is 1 from the next edge on and no watchdog reset starts.
- R8: When `wd_float_i` returns to 0, the watchdog starts counting from zero. The status falls WD_TIMEOUT edges later if no edge arrives.
- R9: While `pwr_good_i` is 0, `wd_stat_n_o` is 1 from the next clock edge on, whatever `wd_level_i` does.
- R10: `rst_out_o` is always the inverse of `rst_out_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_good_i | input | 1 | Synchronized supply-above-threshold level |
| wd_level_i | input | 1 | Decoded watchdog input logic level (asynchronous) |
| wd_float_i | input | 1 | Watchdog input at mid-level or floating; disables the watchdog |
| rst_out_n_o | output | 1 | System reset, active low |
| rst_out_o | output | 1 | System reset, active high |
| wd_stat_n_o | output | 1 | Watchdog status, low after a timeout |

## Verification
The hardest cases to reach are an edge on the watchdog input that arrives while a timeout reset pulse is still running, and the return from the disabled state with a stale count. The stimulus first lets the input stay stuck through two full timeout cycles. It then toggles the input in the middle of the second pulse and checks two things: the status recovers, and the next timeout is measured from the release of reset. Next it stops toggling, lets a timeout fire, and raises the float flag in the very cycle of the timeout. This shows that the float flag clears the status while the pulse already started still runs to its end. Finally it drops the float flag and times the next timeout from zero.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Width needed to hold the values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/supv_wd_sync.sv
module supv_wd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic edge_o
);
  // One extra flop past the synchronizer holds the previous sample
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], level_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/supv_hold_stretch.sv
module supv_hold_stretch
  import supv_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rst_act_o
);
  localparam int CW = cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    if (trig_i)             cnt_d = HOLD_LD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = '0;
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= HOLD_LD;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign rst_act_o = act_q;
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer
  import supv_pkg::*;
#(
  parameter int WD_TIMEOUT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic float_i,
  input  logic edge_i,
  input  logic rst_act_i,
  output logic fire_o,
  output logic stat_n_o
);
  localparam int CW = cnt_w(WD_TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(WD_TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stat_q, stat_d;
  logic          fire_q, fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    fire_d = 1'b0;
    if (!pwr_good_i || float_i) begin
      cnt_d  = '0;
      stat_d = 1'b1;
    end else begin
      if (edge_i) stat_d = 1'b1;
      if (rst_act_i || edge_i) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        cnt_d  = '0;
        fire_d = 1'b1;
        stat_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b1;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o   = fire_q;
  assign stat_n_o = stat_q;
endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
  parameter int HOLD_CYCLES = 8,
  parameter int WD_TIMEOUT  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic wd_level_i,
  input  logic wd_float_i,
  output logic rst_out_n_o,
  output logic rst_out_o,
  output logic wd_stat_n_o
);
  logic wd_edge;
  logic wd_fire;
  logic rst_act;
  logic hold_trig;

  supv_wd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (wd_level_i),
    .edge_o  (wd_edge)
  );

  assign hold_trig = !pwr_good_i || wd_fire;

  supv_hold_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (hold_trig),
    .rst_act_o (rst_act)
  );

  supv_wd_timer #(.WD_TIMEOUT(WD_TIMEOUT)) u_wdt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .float_i    (wd_float_i),
    .edge_i     (wd_edge),
    .rst_act_i  (rst_act),
    .fire_o     (wd_fire),
    .stat_n_o   (wd_stat_n_o)
  );

  assign rst_out_n_o = ~rst_act;
  assign rst_out_o   = rst_act;
endmodule

// File: rtl/proc_supervisor_chk.sv
module proc_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good_i,
  input logic wd_float_i,
  input logic rst_out_n_o,
  input logic rst_out_o,
  input logic wd_stat_n_o
);
  // R1
  pwr_low_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> !rst_out_n_o);

  // R9
  pwr_low_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> wd_stat_n_o);

  // R7
  float_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float_i |=> wd_stat_n_o);

  // R4
  timeout_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_stat_n_o) |=> !rst_out_n_o);

  // R2
  release_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n_o) |-> $past(pwr_good_i));

  // R10
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_o != rst_out_n_o);
endmodule

bind proc_supervisor proc_supervisor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_good_i  (pwr_good_i),
  .wd_float_i  (wd_float_i),
  .rst_out_n_o (rst_out_n_o),
  .rst_out_o   (rst_out_o),
  .wd_stat_n_o (wd_stat_n_o)
);

// File: tb/proc_supervisor_tb.sv
module proc_supervisor_tb;
  localparam int H = 8;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n, pg, lvl, fl;
  logic rstn_o, rst_o, stat_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  proc_supervisor #(.HOLD_CYCLES(H), .WD_TIMEOUT(T)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good_i  (pg),
    .wd_level_i  (lvl),
    .wd_float_i  (fl),
    .rst_out_n_o (rstn_o),
    .rst_out_o   (rst_o),
    .wd_stat_n_o (stat_o)
  );

  // {pg, lvl, fl, wait[7:0], exp_rstn, exp_stat, req[3:0]}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {3'b100, 8'd7,  2'b01, 4'd2},   // R2 still held
    {3'b100, 8'd1,  2'b11, 4'd2},   // R2 released
    {3'b100, 8'd19, 2'b11, 4'd4},   // R4 before timeout
    {3'b100, 8'd1,  2'b10, 4'd4},   // R4 status drops
    {3'b100, 8'd1,  2'b00, 4'd4},   // R4 reset pulse starts
    {3'b100, 8'd7,  2'b00, 4'd4},   // R4 pulse still on
    {3'b100, 8'd1,  2'b10, 4'd4},   // R4 pulse width H
    {3'b100, 8'd20, 2'b10, 4'd5},   // R5 before repeat
    {3'b100, 8'd1,  2'b00, 4'd5},   // R5 repeat pulse
    {3'b110, 8'd3,  2'b01, 4'd6},   // R6 edge in pulse clears status
    {3'b110, 8'd4,  2'b01, 4'd6},   // R6 pulse continues
    {3'b110, 8'd1,  2'b11, 4'd6}    // R6 pulse ends on time
  };

  task automatic check(input logic exp_rn, input logic exp_st, input int req);
    checks++;
    if (rstn_o !== exp_rn || stat_o !== exp_st || rst_o !== ~exp_rn) begin
      fails++;
      $display("FAIL R%0d: rst_n=%b rst=%b stat_n=%b expected rst_n=%b rst=%b stat_n=%b",
               req, rstn_o, rst_o, stat_o, exp_rn, ~exp_rn, exp_st);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pg = 1'b0; lvl = 1'b0; fl = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    check(1'b0, 1'b1, 1);  // R1 reset state with power low

    for (int i = 0; i < NV; i++) begin
      pg  = VEC[i][16];
      lvl = VEC[i][15];
      fl  = VEC[i][14];
      wait_n(int'(VEC[i][13:6]));
      check(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R3: toggle every 10 cycles, no reset
    for (int i = 0; i < 6; i++) begin
      lvl = ~lvl;
      wait_n(10);
      check(1'b1, 1'b1, 3);
    end
    wait_n(12);
    check(1'b1, 1'b1, 3);   // R3 timeout measured from last edge
    wait_n(1);
    check(1'b1, 1'b0, 3);

    // R7: float in the timeout cycle
    fl = 1'b1;
    wait_n(1);
    check(1'b0, 1'b1, 7);
    wait_n(H);
    check(1'b1, 1'b1, 7);
    begin
      int bad = 0;
      for (int i = 0; i < 3 * T; i++) begin
        wait_n(1);
        if (rstn_o !== 1'b1 || stat_o !== 1'b1) bad++;
      end
      checks++;
      if (bad != 0) begin
        fails++;
        $display("FAIL R7: %0d bad samples while disabled, expected 0", bad);
      end
    end

    // R8: count restarts from zero when enabled again
    fl = 1'b0;
    wait_n(T - 1);
    check(1'b1, 1'b1, 8);
    wait_n(1);
    check(1'b1, 1'b0, 8);

    // R1 / R9: power loss forces reset and status high
    pg = 1'b0;
    wait_n(1);
    check(1'b0, 1'b1, 9);
    for (int i = 0; i < 5; i++) begin
      lvl = ~lvl;
      wait_n(1);
    end
    check(1'b0, 1'b1, 9);
    check(1'b0, 1'b1, 1);

    // R2: hold after recovery
    pg = 1'b1;
    wait_n(H - 1);
    check(1'b0, 1'b1, 2);
    wait_n(1);
    check(1'b1, 1'b1, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule